// File: doc/BRIEF.md
# Compressed Instruction Mode Sequencer

This block tracks which instruction-stream mode a fetch/decode front end is in. There are three modes: standard 32-bit, a one-step 10-bit compressed mode, and a sustained 16-bit compressed mode. Each cycle the block may receive one valid halfword. With each halfword comes a flag that says whether the enclosing 32-bit word carries a compressed-entry major opcode. The block reports the current mode. It also reports a same-cycle flag that marks immediate-form compressed halfwords, and a pending flag. The pending flag means that one standard instruction is being run before the stream returns to 16-bit mode.

A standard instruction takes two valid halfwords. An entry opcode is recognised only on the first halfword of a standard word. The next valid halfword is then the 10-bit compressed one. Its least significant bit decides whether the stream goes on in 16-bit mode or drops back to standard. Inside 16-bit mode, the most and least significant bits of every halfword decide what happens next: stay, leave, or leave for exactly one standard instruction and then come back.

Top module: `cmode_seq`

## Requirements
- R1: A synchronous reset gives mode standard and a clear pending flag. The mode encoding is standard = 0, 10-bit = 1, 16-bit = 2.
- R2: On a cycle with `hw_valid` low, the mode and the pending flag do not change.
- R3: In standard mode with no return pending, a valid halfword that is the first of its 32-bit word and has `entry_op` set gives 10-bit mode on the next cycle. `entry_op` on the second halfword of a word has no effect.
- R4: In 10-bit mode the next valid halfword is checked at bit 15, which is `hw[0]`, since bit 0 is the MSB `hw[15]`. If bit 15 is set, the mode goes to 16-bit. If it is clear, the mode goes to standard.
- R5: In 16-bit mode, a valid halfword with bit 0 (`hw[15]`) and bit 15 (`hw[0]`) both set raises `imm_form` in that same cycle, and the mode stays 16-bit.
- R6: In 16-bit mode, a valid halfword with bit 15 set and bit 0 clear keeps 16-bit mode, with `imm_form` low.
- R7: In 16-bit mode, a valid halfword with bit 15 and bit 0 both clear gives standard mode with no return pending.
- R8: In 16-bit mode, a valid halfword with bit 15 clear and bit 0 set gives standard mode with `ret_pending` high. After exactly two more valid halfwords, the mode is 16-bit again and `ret_pending` is low.
- R9: While `ret_pending` is high, `entry_op` has no effect.
- R10: `imm_form` is low whenever the mode is not 16-bit or `hw_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hw_valid | input | 1 | The halfword on `hw` is valid this cycle |
| hw | input | 16 | Instruction halfword; `hw[15]` is bit 0 |
| entry_op | input | 1 | The enclosing word carries a compressed-entry major opcode |
| mode | output | 2 | Current mode: 0 standard, 1 10-bit, 2 16-bit |
| imm_form | output | 1 | The current halfword is an immediate-form compressed instruction |
| ret_pending | output | 1 | One standard instruction is running before the return to 16-bit mode |

## Verification
Random halfwords are mixed with random valid gaps and entry flags. This shows whether the mode only moves on valid cycles, and whether entry is honoured only on the first halfword of a word. Directed runs go into 16-bit mode and then apply each of the four bit 0 / bit 15 combinations. These separate staying, plain exit, immediate flagging and the one-instruction detour. A detour with `entry_op` held high on both halfwords shows whether the pending return takes priority over a fresh entry. Gaps inside the detour show that the two-halfword count ignores invalid cycles.

// File: rtl/cmode_seq_pkg.sv
package cmode_seq_pkg;
   typedef enum logic [1:0] {
      MODE_STD = 2'd0,
      MODE_C10 = 2'd1,
      MODE_C16 = 2'd2
   } cm_mode_e;
endpackage

// File: rtl/cm_hw_class.sv
module cm_hw_class #(
   parameter int HW_W      = 16,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic [HW_W-1:0] hw,
   output logic            lead_bit,
   output logic            tail_bit
);
   initial begin
      if (HW_W < 2) $error("cm_hw_class: HW_W must be at least 2");
   end

   generate
      if (MSB_FIRST) begin : g_msb
         assign lead_bit = hw[HW_W-1];
         assign tail_bit = hw[0];
      end else begin : g_lsb
         assign lead_bit = hw[0];
         assign tail_bit = hw[HW_W-1];
      end
   endgenerate
endmodule

// File: rtl/cm_word_phase.sv
module cm_word_phase #(
   parameter int HWS = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic en,
   output logic first,
   output logic last
);
   localparam int CW = (HWS > 1) ? $clog2(HWS) : 1;
   localparam logic [CW-1:0] LAST_V = CW'(HWS - 1);

   logic [CW-1:0] cnt_q;

   initial begin
      if (HWS < 1) $error("cm_word_phase: HWS must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst || clr)     cnt_q <= '0;
      else if (en)        cnt_q <= (cnt_q == LAST_V) ? '0 : cnt_q + 1'b1;
   end

   assign first = (cnt_q == '0);
   assign last  = en && (cnt_q == LAST_V);

   // R8
   phase_range_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LAST_V);
endmodule

// File: rtl/cmode_seq.sv
module cmode_seq
   import cmode_seq_pkg::*;
#(
   parameter int HW_W      = 16,
   parameter int PEND_HWS  = 2,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            hw_valid,
   input  logic [HW_W-1:0] hw,
   input  logic            entry_op,
   output logic [1:0]      mode,
   output logic            imm_form,
   output logic            ret_pending
);
   cm_mode_e mode_q, mode_n;
   logic     pend_q, pend_n;
   logic     lead_bit, tail_bit;
   logic     word_first, word_last;
   logic     in_std, go_c10, back16, ph_clr;

   initial begin
      if (PEND_HWS < 1) $error("cmode_seq: PEND_HWS must be at least 1");
   end

   cm_hw_class #(.HW_W(HW_W), .MSB_FIRST(MSB_FIRST)) u_class (
      .hw       (hw),
      .lead_bit (lead_bit),
      .tail_bit (tail_bit)
   );

   assign in_std = (mode_q == MODE_STD);
   assign go_c10 = in_std && !pend_q && hw_valid && entry_op && word_first;
   assign back16 = in_std && pend_q && word_last;
   assign ph_clr = !in_std || go_c10 || back16;

   cm_word_phase #(.HWS(PEND_HWS)) u_phase (
      .clk   (clk),
      .rst   (rst),
      .clr   (ph_clr),
      .en    (hw_valid && in_std),
      .first (word_first),
      .last  (word_last)
   );

   always_comb begin
      mode_n = mode_q;
      pend_n = pend_q;
      unique case (mode_q)
         MODE_STD: begin
            if (back16) begin
               mode_n = MODE_C16;
               pend_n = 1'b0;
            end else if (go_c10) begin
               mode_n = MODE_C10;
            end
         end
         MODE_C10: begin
            if (hw_valid) mode_n = tail_bit ? MODE_C16 : MODE_STD;
         end
         MODE_C16: begin
            if (hw_valid && !tail_bit) begin
               mode_n = MODE_STD;
               pend_n = lead_bit;
            end
         end
         default: begin
            mode_n = MODE_STD;
            pend_n = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= MODE_STD;
         pend_q <= 1'b0;
      end else begin
         mode_q <= mode_n;
         pend_q <= pend_n;
      end
   end

   assign mode        = mode_q;
   assign ret_pending = pend_q;
   assign imm_form    = hw_valid && (mode_q == MODE_C16) && lead_bit && tail_bit;

   // R2
   hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !hw_valid |=> ($stable(mode) && $stable(ret_pending)));
   // R8
   pend_std_only_chk: assert property (@(posedge clk) disable iff (rst)
      ret_pending |-> (mode == 2'd0));
   // R4
   c10_single_chk: assert property (@(posedge clk) disable iff (rst)
      (mode == 2'd1 && hw_valid) |=> (mode != 2'd1));
   // R3
   c10_entry_chk: assert property (@(posedge clk) disable iff (rst)
      (mode == 2'd0 && hw_valid && entry_op && !ret_pending && word_first) |=> (mode == 2'd1));
   // R10
   imm_mode_chk: assert property (@(posedge clk) disable iff (rst)
      imm_form |-> (mode == 2'd2 && hw_valid));
   // R5
   imm_stay_chk: assert property (@(posedge clk) disable iff (rst)
      imm_form |=> (mode == 2'd2));
endmodule

// File: tb/cmode_seq_tb.sv
`timescale 1ns/1ps
module cmode_seq_tb;
   logic        clk = 1'b0;
   logic        rst;
   logic        hw_valid;
   logic [15:0] hw;
   logic        entry_op;
   logic [1:0]  mode;
   logic        imm_form;
   logic        ret_pending;

   int checks = 0;
   int errors = 0;

   logic [1:0] m_mode;
   logic       m_pend;
   int         m_cnt;
   string      m_tag;

   always #4 clk = ~clk;

   cmode_seq u_dut (
      .clk(clk), .rst(rst), .hw_valid(hw_valid), .hw(hw),
      .entry_op(entry_op), .mode(mode), .imm_form(imm_form),
      .ret_pending(ret_pending)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic logic exp_imm(input logic [1:0] m, input logic v, input logic [15:0] h);
      return v && (m == 2'd2) && h[15] && h[0];
   endfunction

   // Reference model of one clock edge.
   task automatic model_step(input logic v, input logic e, input logic [15:0] h);
      logic b0, b15;
      b0 = h[15];
      b15 = h[0];
      if (!v) begin
         m_tag = "R2";
         return;
      end
      case (m_mode)
         2'd0: begin
            if (m_pend) begin
               m_tag = e ? "R9" : "R8";
               if (m_cnt == 1) begin
                  m_mode = 2'd2; m_pend = 1'b0; m_cnt = 0;
               end else m_cnt = 1;
            end else begin
               m_tag = "R3";
               if (m_cnt == 0 && e) begin
                  m_mode = 2'd1; m_cnt = 0;
               end else m_cnt = (m_cnt == 0) ? 1 : 0;
            end
         end
         2'd1: begin
            m_tag = "R4";
            m_mode = b15 ? 2'd2 : 2'd0;
            m_cnt = 0;
         end
         default: begin
            if (b0 && b15)       m_tag = "R5";
            else if (b15)        m_tag = "R6";
            else if (!b0)        m_tag = "R7";
            else                 m_tag = "R8";
            if (!b15) begin
               m_mode = 2'd0; m_pend = b0; m_cnt = 0;
            end
         end
      endcase
   endtask

   // Drive one cycle, check the same-cycle flag, then check state after the edge.
   task automatic drive(input logic v, input logic e, input logic [15:0] h);
      logic ei;
      @(negedge clk);
      hw_valid = v; entry_op = e; hw = h;
      #1;
      ei = exp_imm(m_mode, v, h);
      check(ei ? "R5" : "R10", "imm_form", int'(imm_form), int'(ei));
      model_step(v, e, h);
      @(negedge clk);
      check(m_tag, "mode", int'(mode), int'(m_mode));
      check(m_tag, "ret_pending", int'(ret_pending), int'(m_pend));
      hw_valid = 1'b0; entry_op = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_c0de));
      rst = 1'b1; hw_valid = 1'b0; entry_op = 1'b0; hw = '0;
      m_mode = 2'd0; m_pend = 1'b0; m_cnt = 0; m_tag = "R1";
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      check("R1", "mode", int'(mode), 0);
      check("R1", "ret_pending", int'(ret_pending), 0);
      check("R1", "imm_form", int'(imm_form), 0);

      // R3 entry on second halfword ignored, then entry on first taken
      drive(1, 0, 16'h1234);
      drive(1, 1, 16'h1234);
      drive(1, 1, 16'h0000);
      // R4 bit15 set goes to 16-bit
      drive(1, 0, 16'h0001);
      // R5, R6 stay in 16-bit
      drive(1, 0, 16'h8001);
      drive(1, 0, 16'h0003);
      drive(0, 0, 16'h8001);
      // R8 detour with gaps, R9 entry during detour
      drive(1, 0, 16'h8000);
      drive(1, 1, 16'h0000);
      drive(0, 1, 16'h0000);
      drive(1, 1, 16'hffff);
      // back in 16-bit: R7 plain exit
      drive(1, 0, 16'h7ffe);
      // R4 bit15 clear exits 10-bit
      drive(1, 1, 16'h0000);
      drive(1, 0, 16'hfffe);

      for (int i = 0; i < 4000; i++) begin
         logic v, e;
         logic [15:0] h;
         v = ($urandom % 10) < 7;
         e = ($urandom % 10) < 3;
         h = 16'($urandom);
         drive(v, e, h);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule